// File: doc/BRIEF.md
# Single-Operand Shift and Rotate Unit

This unit performs one shift or rotate on an operand that is 8, 16 or 32 bits wide. It supports shift left (under two opcodes that behave the same), logical shift right, arithmetic shift right, and rotates in both directions. Each rotate direction has a plain form and a form that passes through carry. Alongside the result it produces new carry, overflow, sign, zero and parity values, plus one write-enable per flag. The enables let the surrounding datapath update only the flags that the operation really defines.

All inputs are sampled on a rising clock edge. The result, the flags and the enables appear on the registered outputs after that same edge. Only the low five bits of the count are used. Result bits above the selected size are always zero. A flag whose enable is low is driven out unchanged from its incoming value.

Top module: `shift_rotate_unit`

## Requirements
- R1: While `rst_n` is low, every output is zero. Outputs are registered: inputs seen at a rising edge appear after that edge.
- R2: The count used is `count_in[4:0]`. When that masked count is zero, the result equals the operand at the selected size (`size_sel` 0 = 8, 1 = 16, 2 or 3 = 32 bits), all five enables are low, and each flag output equals its input.
- R3: Opcodes 0 and 1 shift left, filling with zeros. Carry is the last bit shifted out of the top bit, or 0 once the count exceeds the width.
- R4: Opcode 2 shifts right, filling with zeros. Carry is the last bit shifted out of bit 0. As an example, 16-bit 0xFFFF shifted by 1 gives 0x7FFF.
- R5: Opcode 3 shifts right and copies the sign bit into vacated positions. As an example, 8-bit 0xF1 (-15) shifted by 1 gives 0xF8 (-8).
- R6: Opcode 4 rotates left and opcode 5 rotates right, both modulo the width. Carry is the bit that last wrapped around.
- R7: Opcodes 6 and 7 rotate left and right through carry, treating carry as an extra top bit. A count of width+1 returns the operand and the carry unchanged.
- R8: For a nonzero count, the carry enable is high on every opcode.
- R9: The overflow enable is high only when the masked count is 1. Overflow is then set when the top bit of the result differs from the top bit of the operand.
- R10: For shifts with a nonzero count, the sign, zero and parity enables are high. Sign is the result's top bit, zero means the result is all zero, and parity is 1 when the result's low byte has an even number of ones.
- R11: Rotates (opcodes 4 to 7) never raise the sign, zero or parity enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Operation select (0..7) |
| size_sel | input | 2 | Operand size select |
| operand_in | input | 32 | Operand, low bits used at smaller sizes |
| count_in | input | 8 | Shift or rotate count, masked to 5 bits |
| carry_in | input | 1 | Incoming carry |
| ovf_in | input | 1 | Incoming overflow |
| sign_in | input | 1 | Incoming sign |
| zero_in | input | 1 | Incoming zero |
| parity_in | input | 1 | Incoming parity |
| result_o | output | 32 | Result, zero above the selected size |
| carry_o | output | 1 | Carry flag value |
| ovf_o | output | 1 | Overflow flag value |
| sign_o | output | 1 | Sign flag value |
| zero_o | output | 1 | Zero flag value |
| parity_o | output | 1 | Parity flag value |
| carry_we | output | 1 | Carry write-enable |
| ovf_we | output | 1 | Overflow write-enable |
| sign_we | output | 1 | Sign write-enable |
| zero_we | output | 1 | Zero write-enable |
| parity_we | output | 1 | Parity write-enable |

## Verification
A wrong rotate modulus or a wrong carry position shows up in the very next registered result. It typically appears only for particular counts, such as those beyond the width or equal to width+1, so counts across the full 0..31 range are driven at every size. A wrong enable shows up on the same cycle as a write-enable that is set on a rotate or left clear on a shift. A wrong pass-through value is caught because every flag output is compared on every cycle, including cycles where its enable is low.

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  op,
  input  logic [1:0]  size_sel,
  input  logic [31:0] operand_in,
  input  logic [7:0]  count_in,
  input  logic        carry_in,
  input  logic        ovf_in,
  input  logic        sign_in,
  input  logic        zero_in,
  input  logic        parity_in,
  output logic [31:0] result_o,
  output logic        carry_o,
  output logic        ovf_o,
  output logic        sign_o,
  output logic        zero_o,
  output logic        parity_o,
  output logic        carry_we,
  output logic        ovf_we,
  output logic        sign_we,
  output logic        zero_we,
  output logic        parity_we
);
  localparam logic [2:0] OP_SHL = 3'd0, OP_SAL = 3'd1, OP_SHR = 3'd2, OP_SAR = 3'd3,
                         OP_ROL = 3'd4, OP_ROR = 3'd5, OP_RCL = 3'd6, OP_RCR = 3'd7;

  logic [4:0]  cnt;
  logic [5:0]  w, n, k, kc;
  logic [31:0] mask, x, sx;
  logic [33:0] nmask, y, rcl_t, rcr_t;
  logic [63:0] shl_t, shr_t;
  logic signed [63:0] sar_t;
  logic [31:0] rol_r, ror_r, res;
  logic        cf, nz;

  assign cnt = count_in[4:0];
  assign nz  = cnt != 5'd0;

  always_comb begin
    case (size_sel)
      2'd0: begin w = 6'd8;  mask = 32'h0000_00FF; k = {3'd0, cnt[2:0]};
              kc = (cnt >= 5'd27) ? 6'(cnt) - 6'd27 : (cnt >= 5'd18) ? 6'(cnt) - 6'd18 :
                   (cnt >= 5'd9)  ? 6'(cnt) - 6'd9  : 6'(cnt); end
      2'd1: begin w = 6'd16; mask = 32'h0000_FFFF; k = {2'd0, cnt[3:0]};
              kc = (cnt >= 5'd17) ? 6'(cnt) - 6'd17 : 6'(cnt); end
      default: begin w = 6'd32; mask = 32'hFFFF_FFFF; k = 6'(cnt); kc = 6'(cnt); end
    endcase
  end

  assign n     = w + 6'd1;
  assign nmask = (34'd1 << n) - 34'd1;
  assign x     = operand_in & mask;
  assign sx    = x[w - 6'd1] ? (x | ~mask) : x;

  assign shl_t = {32'd0, x} << cnt;
  assign shr_t = {x, 32'd0} >> cnt;
  assign sar_t = $signed({sx, 32'd0}) >>> cnt;
  assign rol_r = ((x << k) | (x >> (w - k))) & mask;
  assign ror_r = ((x >> k) | (x << (w - k))) & mask;
  assign y     = {2'b00, x} | ({33'd0, carry_in} << w);
  assign rcl_t = ((y << kc) | (y >> (n - kc))) & nmask;
  assign rcr_t = ((y >> kc) | (y << (n - kc))) & nmask;

  always_comb begin
    case (op)
      OP_SHL, OP_SAL: begin res = shl_t[31:0] & mask;  cf = shl_t[w];       end
      OP_SHR:         begin res = shr_t[63:32];        cf = shr_t[31];      end
      OP_SAR:         begin res = sar_t[63:32] & mask; cf = sar_t[31];      end
      OP_ROL:         begin res = rol_r;               cf = rol_r[0];       end
      OP_ROR:         begin res = ror_r;               cf = ror_r[w - 6'd1]; end
      OP_RCL:         begin res = rcl_t[31:0] & mask;  cf = rcl_t[w];       end
      default:        begin res = rcr_t[31:0] & mask;  cf = rcr_t[w];       end
    endcase
    if (!nz) res = x;
  end

  logic szp_we, o_we;
  assign szp_we = nz & ~op[2];
  assign o_we   = cnt == 5'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o <= '0; carry_o <= 1'b0; ovf_o <= 1'b0; sign_o <= 1'b0;
      zero_o <= 1'b0; parity_o <= 1'b0; carry_we <= 1'b0; ovf_we <= 1'b0;
      sign_we <= 1'b0; zero_we <= 1'b0; parity_we <= 1'b0;
    end else begin
      result_o  <= res;
      carry_o   <= nz ? cf : carry_in;
      ovf_o     <= o_we ? (res[w - 6'd1] ^ x[w - 6'd1]) : ovf_in;
      sign_o    <= szp_we ? res[w - 6'd1] : sign_in;
      zero_o    <= szp_we ? (res == 32'd0) : zero_in;
      parity_o  <= szp_we ? ~^res[7:0] : parity_in;
      carry_we  <= nz;
      ovf_we    <= o_we;
      sign_we   <= szp_we;
      zero_we   <= szp_we;
      parity_we <= szp_we;
    end
  end
endmodule

// File: rtl/shift_rotate_unit_chk.sv
module shift_rotate_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  op,
  input logic [1:0]  size_sel,
  input logic [7:0]  count_in,
  input logic        carry_in,
  input logic        ovf_in,
  input logic [31:0] result_o,
  input logic        carry_o,
  input logic        ovf_o,
  input logic        carry_we,
  input logic        ovf_we,
  input logic        sign_we,
  input logic        zero_we,
  input logic        parity_we
);
  a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=>
    (result_o == 32'd0 && !carry_we && !ovf_we && !sign_we && !zero_we && !parity_we));

  a_r2_zero_count_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (count_in[4:0] == 5'd0) |=>
      (!carry_we && !ovf_we && !sign_we && !zero_we && !parity_we));

  a_r2_zero_count_passes_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (count_in[4:0] == 5'd0) |=> (carry_o == $past(carry_in) && ovf_o == $past(ovf_in)));

  a_r8_carry_we_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (count_in[4:0] != 5'd0) |=> carry_we);

  a_r9_ovf_only_count_one: assert property (@(posedge clk) disable iff (!rst_n)
    (count_in[4:0] != 5'd1) |=> (!ovf_we && ovf_o == $past(ovf_in)));

  a_r10_shift_writes_szp: assert property (@(posedge clk) disable iff (!rst_n)
    (!op[2] && count_in[4:0] != 5'd0) |=> (sign_we && zero_we && parity_we));

  a_r11_rotate_keeps_szp: assert property (@(posedge clk) disable iff (!rst_n)
    op[2] |=> (!sign_we && !zero_we && !parity_we));

  a_r2_byte_size_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (size_sel == 2'd0) |=> (result_o[31:8] == 24'd0));
endmodule

bind shift_rotate_unit shift_rotate_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .size_sel(size_sel), .count_in(count_in),
  .carry_in(carry_in), .ovf_in(ovf_in), .result_o(result_o), .carry_o(carry_o),
  .ovf_o(ovf_o), .carry_we(carry_we), .ovf_we(ovf_we), .sign_we(sign_we),
  .zero_we(zero_we), .parity_we(parity_we)
);

// File: tb/tb_shift_rotate_unit.sv
module tb_shift_rotate_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] op = '0;
  logic [1:0] size_sel = '0;
  logic [31:0] operand_in = '0;
  logic [7:0] count_in = '0;
  logic carry_in = 0, ovf_in = 0, sign_in = 0, zero_in = 0, parity_in = 0;
  logic [31:0] result_o;
  logic carry_o, ovf_o, sign_o, zero_o, parity_o;
  logic carry_we, ovf_we, sign_we, zero_we, parity_we;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shift_rotate_unit dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (op=%0d size=%0d x=%h cnt=%0d)",
               req, act, exp, op, size_sel, operand_in, count_in);
    end
  endtask

  task automatic model(input logic [2:0] o, input logic [1:0] s, input logic [31:0] xin,
                       input logic [7:0] cin, input logic ci, input logic oi,
                       input logic si, input logic zi, input logic pi,
                       output logic [31:0] r, output logic [4:0] fl, output logic [4:0] we);
    int wd;
    logic [31:0] m, x0, x;
    logic c, b;
    int cnt;
    wd = (s == 0) ? 8 : (s == 1) ? 16 : 32;
    m = (wd == 32) ? 32'hFFFF_FFFF : ((32'd1 << wd) - 1);
    x0 = xin & m; x = x0; c = ci; cnt = int'(cin & 8'h1F);
    for (int i = 0; i < cnt; i++) begin
      case (o)
        0, 1: begin c = x[wd-1]; x = (x << 1) & m; end
        2:    begin c = x[0]; x = x >> 1; end
        3:    begin c = x[0]; x = (x >> 1) | ({31'd0, x[wd-1]} << (wd-1)); end
        4:    begin b = x[wd-1]; x = ((x << 1) | {31'd0, b}) & m; c = b; end
        5:    begin b = x[0]; x = (x >> 1) | ({31'd0, b} << (wd-1)); c = b; end
        6:    begin b = x[wd-1]; x = ((x << 1) | {31'd0, c}) & m; c = b; end
        default: begin b = x[0]; x = (x >> 1) | ({31'd0, c} << (wd-1)); c = b; end
      endcase
    end
    r = x;
    if (cnt == 0) begin
      fl = {ci, oi, si, zi, pi}; we = 5'b0;
    end else begin
      we[4] = 1'b1;
      we[3] = (cnt == 1);
      we[2:0] = (o >= 4) ? 3'b000 : 3'b111;
      fl[4] = c;
      fl[3] = we[3] ? (x[wd-1] ^ x0[wd-1]) : oi;
      fl[2] = we[2] ? x[wd-1] : si;
      fl[1] = we[1] ? (x == 0) : zi;
      fl[0] = we[0] ? ~^x[7:0] : pi;
    end
  endtask

  function automatic string tag(input logic [2:0] o);
    case (o)
      0, 1: return "R3";
      2: return "R4";
      3: return "R5";
      4, 5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [2:0] o, input logic [1:0] s, input logic [31:0] xv,
                       input logic [7:0] cv, input logic [4:0] fin);
    logic [31:0] er;
    logic [4:0] ef, ew;
    @(negedge clk);
    op = o; size_sel = s; operand_in = xv; count_in = cv;
    {carry_in, ovf_in, sign_in, zero_in, parity_in} = fin;
    model(o, s, xv, cv, fin[4], fin[3], fin[2], fin[1], fin[0], er, ef, ew);
    @(negedge clk);
    check((cv[4:0] == 0) ? "R2 result" : {tag(o), " result"}, result_o, er);
    check({tag(o), " carry"}, {31'd0, carry_o}, {31'd0, ef[4]});
    check("R9 overflow", {31'd0, ovf_o}, {31'd0, ef[3]});
    check("R10 sign/zero/parity", {29'd0, sign_o, zero_o, parity_o}, {29'd0, ef[2:0]});
    check((o >= 4) ? "R11 enables" : "R8 enables",
          {27'd0, carry_we, ovf_we, sign_we, zero_we, parity_we}, {27'd0, ew});
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset result", result_o, 32'd0);
    check("R1 reset enables", {27'd0, carry_we, ovf_we, sign_we, zero_we, parity_we}, 32'd0);
    rst_n = 1'b1;

    // R5: -15 arithmetic right by one is -8
    apply(3'd3, 2'd0, 32'h0000_00F1, 8'd1, 5'b0);
    check("R5 example", result_o, 32'h0000_00F8);
    // R4: 0xFFFF logical right by one
    apply(3'd2, 2'd1, 32'h0000_FFFF, 8'd1, 5'b0);
    check("R4 example", result_o, 32'h0000_7FFF);
    // R7: rotating through carry width+1 times restores operand and carry
    apply(3'd6, 2'd0, 32'h0000_00A5, 8'd9, 5'b10000);
    check("R7 restore", {31'd0, carry_o, result_o[7:0]}, {31'd0, 1'b1, 8'hA5});
    apply(3'd7, 2'd1, 32'h0000_1234, 8'd17, 5'b00000);
    check("R7 restore rcr", {15'd0, carry_o, result_o[15:0]}, {15'd0, 1'b0, 16'h1234});
    // R2: masked count zero (count 32) passes everything through
    apply(3'd0, 2'd2, 32'h8000_0001, 8'd32, 5'b10101);
    check("R2 pass flags", {27'd0, carry_o, ovf_o, sign_o, zero_o, parity_o}, 32'h15);
    // R3: left shift by more than width clears carry; opcode 1 equals opcode 0
    apply(3'd1, 2'd0, 32'h0000_00FF, 8'd12, 5'b10000);
    check("R3 over width", {31'd0, carry_o}, 32'd0);
    // R11: rotate leaves sign/zero/parity values untouched
    apply(3'd4, 2'd2, 32'h8000_0000, 8'd1, 5'b00111);
    check("R11 flags kept", {29'd0, sign_o, zero_o, parity_o}, 32'h7);

    for (int op_i = 0; op_i < 8; op_i++)
      for (int s_i = 0; s_i < 4; s_i++)
        for (int c_i = 0; c_i < 34; c_i += 3)
          apply(3'(op_i), 2'(s_i), $urandom, 8'(c_i + 32 * (c_i % 2)), 5'($urandom));
    for (int i = 0; i < 400; i++)
      apply(3'($urandom), 2'($urandom), $urandom, 8'($urandom), 5'($urandom));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule